// File: doc/BRIEF.md
# Two-Bank Out-of-Order Issue Queue

This block holds arithmetic instructions that have been renamed but cannot start yet, and releases them to the execute pipes once their source operands are available. The queue has two equal banks. Each bank keeps its instruction payload (opcode, two source tags, destination tag) in a small RAM with one write port and one read port. So a bank can take at most one new instruction and hand out at most one instruction per cycle. The per-entry state used for wakeup and selection lives in flip-flops. That state is a valid bit, two source-ready bits, a copy of the two source tags for comparison, and an age matrix.

The dispatch stage offers one instruction per cycle. The queue steers it to whichever bank has more free slots, and takes it only when some bank has room. Result buses broadcast up to two destination tags per cycle, and matching sources become ready. Each bank independently picks its oldest entry whose two sources are ready, reads that entry's RAM row, and presents it on its own registered issue port. A flush input empties both banks at once.

Top module: `iq_banked`

## Requirements
- R1: While reset is asserted and in the first cycle after it, both issue ports show `iss_valid` = 0 and `disp_ready` = 1.
- R2: A dispatch goes to bank 1 only when bank 1 has strictly more free slots than bank 0; otherwise it goes to bank 0. Bank 0 is `iss_valid[0]` and the low field of each packed issue bus; bank 1 is `iss_valid[1]` and the high field.
- R3: `disp_ready` is 0 exactly when all slots of both banks are occupied. A dispatch offered while `disp_ready` is 0 is dropped and never issues.
- R4: Each bank writes at most one new entry and issues at most one entry per cycle, so N ready entries in one bank need N cycles to drain.
- R5: A source becomes ready in the cycle after a valid wakeup lane (`wk_valid[k]`, tag in bits `k*TAG_W +: TAG_W` of `wk_tag`) carries its tag. This also holds for an instruction being dispatched in the same cycle as the broadcast. The entry issues no sooner than two cycles after the broadcast.
- R6: Among the entries of a bank whose two sources are ready, the one dispatched earliest is issued first.
- R7: An entry that is eligible in cycle t appears on its bank's issue port in cycle t+1 with `iss_valid` set and its own opcode, source tags and destination tag. It then leaves the queue and issues exactly once. An instruction dispatched with both sources ready therefore appears two cycles after dispatch.
- R8: In the cycle after `flush` is high, both banks are empty and both `iss_valid` bits are 0. A dispatch offered in the flush cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard every queued entry |
| disp_valid | input | 1 | Dispatch offers an instruction |
| disp_ready | output | 1 | At least one bank has a free slot |
| disp_op | input | OP_W | Opcode of offered instruction |
| disp_src1 | input | TAG_W | First source tag |
| disp_src1_rdy | input | 1 | First source already available |
| disp_src2 | input | TAG_W | Second source tag |
| disp_src2_rdy | input | 1 | Second source already available |
| disp_dst | input | TAG_W | Destination tag |
| wk_valid | input | N_WAKE | Per-lane wakeup strobe |
| wk_tag | input | N_WAKE*TAG_W | Per-lane broadcast destination tags |
| iss_valid | output | 2 | Per-bank issue strobe |
| iss_op | output | 2*OP_W | Per-bank issued opcode |
| iss_src1 | output | 2*TAG_W | Per-bank issued first source tag |
| iss_src2 | output | 2*TAG_W | Per-bank issued second source tag |
| iss_dst | output | 2*TAG_W | Per-bank issued destination tag |

## Verification
`disp_ready` is combinational from queue occupancy, so the bench reads it one time step after driving the inputs, before the edge. Issue ports are registered one stage after selection, and selection sees ready bits that a wakeup set at the previous edge. The bench's reference model therefore steps once per edge: it picks the oldest eligible entry from the state before the edge, then applies wakeups and the dispatch. It compares both issue ports at the following falling edge. This places a ready-at-dispatch instruction two edges after dispatch, and a woken one two edges after its broadcast. Directed phases add exact counts for drop-when-full, drain length and flush.

// File: rtl/iq_pkg.sv
package iq_pkg;
   localparam int NUM_BANKS = 2;

   typedef enum logic {
      BANK_LO = 1'b0,
      BANK_HI = 1'b1
   } bank_e;

   // Steering rule: the upper bank wins only with strictly more room.
   function automatic bank_e steer(input int unsigned free_lo, input int unsigned free_hi);
      return (free_hi > free_lo) ? BANK_HI : BANK_LO;
   endfunction
endpackage

// File: rtl/iq_pay_ram.sv
module iq_pay_ram #(
   parameter int DEPTH = 8,
   parameter int WIDTH = 26,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);
   logic [WIDTH-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/iq_age_sel.sv
module iq_age_sel #(
   parameter int DEPTH = 8,
   localparam int IW = $clog2(DEPTH)
) (
   input  logic [DEPTH-1:0] req,
   input  logic [DEPTH-1:0] older_than [DEPTH],
   output logic [DEPTH-1:0] grant,
   output logic [IW-1:0]    grant_idx,
   output logic             grant_any
);
   for (genvar i = 0; i < DEPTH; i++) begin : g_row
      assign grant[i] = req[i] & ~(|(req & older_than[i]));
   end

   always_comb begin
      grant_idx = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (grant[i]) grant_idx = IW'(i);
      end
   end

   assign grant_any = |req;
endmodule

// File: rtl/iq_bank.sv
module iq_bank #(
   parameter int DEPTH  = 8,
   parameter int TAG_W  = 6,
   parameter int OP_W   = 8,
   parameter int N_WAKE = 2,
   localparam int IW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1),
   localparam int PL_W = OP_W + 3 * TAG_W
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      flush,
   input  logic                      wr_en,
   input  logic [PL_W-1:0]           wr_pl,
   input  logic                      wr_rdy1,
   input  logic                      wr_rdy2,
   input  logic [N_WAKE-1:0]         wk_vld,
   input  logic [N_WAKE*TAG_W-1:0]   wk_tag,
   output logic [CW-1:0]             free_cnt,
   output logic                      iss_vld,
   output logic [PL_W-1:0]           iss_pl
);
   logic [DEPTH-1:0] valid_q, rdy1_q, rdy2_q;
   logic [TAG_W-1:0] s1_q [DEPTH];
   logic [TAG_W-1:0] s2_q [DEPTH];
   logic [DEPTH-1:0] older_q [DEPTH];
   logic [DEPTH-1:0] hit1, hit2, req, grant;
   logic [IW-1:0]    sel_idx, wr_idx;
   logic             sel_any;
   logic [PL_W-1:0]  rd_pl;
   logic [TAG_W-1:0] wr_s1, wr_s2;

   assign wr_s1 = wr_pl[TAG_W-1:0];
   assign wr_s2 = wr_pl[2*TAG_W-1:TAG_W];

   function automatic logic tag_hit(input logic [TAG_W-1:0] t);
      logic h = 1'b0;
      for (int k = 0; k < N_WAKE; k++) begin
         if (wk_vld[k] && wk_tag[k*TAG_W +: TAG_W] == t) h = 1'b1;
      end
      return h;
   endfunction

   for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
      assign hit1[i] = tag_hit(s1_q[i]);
      assign hit2[i] = tag_hit(s2_q[i]);
   end

   assign req = valid_q & rdy1_q & rdy2_q;

   iq_age_sel #(.DEPTH(DEPTH)) u_sel (
      .req(req), .older_than(older_q), .grant(grant),
      .grant_idx(sel_idx), .grant_any(sel_any)
   );

   always_comb begin
      wr_idx   = '0;
      free_cnt = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (!valid_q[i]) begin
            wr_idx   = IW'(i);
            free_cnt = free_cnt + CW'(1);
         end
      end
   end

   iq_pay_ram #(.DEPTH(DEPTH), .WIDTH(PL_W)) u_ram (
      .clk(clk), .we(wr_en), .waddr(wr_idx), .wdata(wr_pl),
      .raddr(sel_idx), .rdata(rd_pl)
   );

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         valid_q <= '0;
         rdy1_q  <= '0;
         rdy2_q  <= '0;
         iss_vld <= 1'b0;
         iss_pl  <= '0;
         for (int i = 0; i < DEPTH; i++) begin
            older_q[i] <= '0;
            s1_q[i]    <= '0;
            s2_q[i]    <= '0;
         end
      end else begin
         rdy1_q  <= rdy1_q | hit1;
         rdy2_q  <= rdy2_q | hit2;
         iss_vld <= sel_any;
         if (sel_any) begin
            valid_q[sel_idx] <= 1'b0;
            iss_pl           <= rd_pl;
         end
         if (wr_en) begin
            for (int j = 0; j < DEPTH; j++) older_q[j][wr_idx] <= 1'b0;
            older_q[wr_idx] <= valid_q;
            valid_q[wr_idx] <= 1'b1;
            rdy1_q[wr_idx]  <= wr_rdy1 | tag_hit(wr_s1);
            rdy2_q[wr_idx]  <= wr_rdy2 | tag_hit(wr_s2);
            s1_q[wr_idx]    <= wr_s1;
            s2_q[wr_idx]    <= wr_s2;
         end
      end
   end

   AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant)); // R4
   AST_NO_WRITE_FULL: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> free_cnt != '0); // R3
   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) flush |=> (valid_q == '0 && !iss_vld)); // R8
   AST_SEL_ISSUES: assert property (@(posedge clk) disable iff (!rst_n) (sel_any && !flush) |=> iss_vld); // R7

   for (genvar i = 0; i < DEPTH; i++) begin : g_chk
      AST_WAKE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
         (valid_q[i] && hit1[i] && !flush) |=> (rdy1_q[i] || !valid_q[i])); // R5
   end
endmodule

// File: rtl/iq_banked.sv
module iq_banked
   import iq_pkg::*;
#(
   parameter int BANK_DEPTH = 8,
   parameter int TAG_W      = 6,
   parameter int OP_W       = 8,
   parameter int N_WAKE     = 2,
   localparam int CW   = $clog2(BANK_DEPTH + 1),
   localparam int PL_W = OP_W + 3 * TAG_W
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         flush,
   input  logic                         disp_valid,
   output logic                         disp_ready,
   input  logic [OP_W-1:0]              disp_op,
   input  logic [TAG_W-1:0]             disp_src1,
   input  logic                         disp_src1_rdy,
   input  logic [TAG_W-1:0]             disp_src2,
   input  logic                         disp_src2_rdy,
   input  logic [TAG_W-1:0]             disp_dst,
   input  logic [N_WAKE-1:0]            wk_valid,
   input  logic [N_WAKE*TAG_W-1:0]      wk_tag,
   output logic [NUM_BANKS-1:0]         iss_valid,
   output logic [NUM_BANKS*OP_W-1:0]    iss_op,
   output logic [NUM_BANKS*TAG_W-1:0]   iss_src1,
   output logic [NUM_BANKS*TAG_W-1:0]   iss_src2,
   output logic [NUM_BANKS*TAG_W-1:0]   iss_dst
);
   if (BANK_DEPTH < 2 || TAG_W < 1 || OP_W < 1 || N_WAKE < 1) begin : g_bad_param
      $error("iq_banked: illegal parameter set");
   end

   logic [CW-1:0]        free_cnt [NUM_BANKS];
   logic [NUM_BANKS-1:0] wr_en, room;
   logic [PL_W-1:0]      disp_pl;
   logic                 fire;
   bank_e                target;

   assign disp_pl    = {disp_op, disp_dst, disp_src2, disp_src1};
   assign disp_ready = |room;
   assign fire       = disp_valid && disp_ready && !flush;
   assign target     = steer(int'(free_cnt[0]), int'(free_cnt[1]));

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic [PL_W-1:0] pl;

      assign room[b]  = free_cnt[b] != '0;
      assign wr_en[b] = fire && (target == bank_e'(b));

      iq_bank #(
         .DEPTH(BANK_DEPTH), .TAG_W(TAG_W), .OP_W(OP_W), .N_WAKE(N_WAKE)
      ) u_bank (
         .clk(clk), .rst_n(rst_n), .flush(flush),
         .wr_en(wr_en[b]), .wr_pl(disp_pl),
         .wr_rdy1(disp_src1_rdy), .wr_rdy2(disp_src2_rdy),
         .wk_vld(wk_valid), .wk_tag(wk_tag),
         .free_cnt(free_cnt[b]), .iss_vld(iss_valid[b]), .iss_pl(pl)
      );

      assign iss_src1[b*TAG_W +: TAG_W] = pl[TAG_W-1:0];
      assign iss_src2[b*TAG_W +: TAG_W] = pl[2*TAG_W-1:TAG_W];
      assign iss_dst[b*TAG_W +: TAG_W]  = pl[3*TAG_W-1:2*TAG_W];
      assign iss_op[b*OP_W +: OP_W]     = pl[PL_W-1:3*TAG_W];
   end

   AST_ONE_BANK_WRITE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(wr_en)); // R4
   AST_STEER_FREER: assert property (@(posedge clk) disable iff (!rst_n) wr_en[1] |-> free_cnt[1] > free_cnt[0]); // R2
   AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n) !disp_ready |-> wr_en == '0); // R3
endmodule

// File: tb/test_iq_banked.sv
module test_iq_banked;
   localparam int CLK_PERIOD = 10;
   localparam int D = 8;
   localparam int TW = 6;
   localparam int OW = 8;
   localparam int NW = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic flush = 1'b0;
   logic disp_valid = 1'b0;
   logic disp_ready;
   logic [OW-1:0] disp_op = '0;
   logic [TW-1:0] disp_src1 = '0, disp_src2 = '0, disp_dst = '0;
   logic disp_src1_rdy = 1'b0, disp_src2_rdy = 1'b0;
   logic [NW-1:0] wk_valid = '0;
   logic [NW*TW-1:0] wk_tag = '0;
   logic [1:0] iss_valid;
   logic [2*OW-1:0] iss_op;
   logic [2*TW-1:0] iss_src1, iss_src2, iss_dst;

   iq_banked #(.BANK_DEPTH(D), .TAG_W(TW), .OP_W(OW), .N_WAKE(NW)) i_iq_banked (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_op(disp_op),
      .disp_src1(disp_src1), .disp_src1_rdy(disp_src1_rdy),
      .disp_src2(disp_src2), .disp_src2_rdy(disp_src2_rdy), .disp_dst(disp_dst),
      .wk_valid(wk_valid), .wk_tag(wk_tag),
      .iss_valid(iss_valid), .iss_op(iss_op), .iss_src1(iss_src1),
      .iss_src2(iss_src2), .iss_dst(iss_dst)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   // reference model
   bit            mv  [2][D];
   bit            mr1 [2][D];
   bit            mr2 [2][D];
   logic [TW-1:0] ms1 [2][D];
   logic [TW-1:0] ms2 [2][D];
   logic [TW-1:0] mdst[2][D];
   logic [OW-1:0] mop [2][D];
   int            mseq[2][D];
   int            seq_ctr = 0;
   bit            ev  [2];
   logic [OW+3*TW-1:0] epl[2];

   int n_chk = 0, n_fail = 0, issued = 0, both_cycles = 0;
   bit done = 1'b0;

   function automatic int mfree(int b);
      int n = 0;
      for (int i = 0; i < D; i++) if (!mv[b][i]) n++;
      return n;
   endfunction

   function automatic bit mhit(logic [TW-1:0] t, logic [1:0] v, logic [TW-1:0] t0, logic [TW-1:0] t1);
      return (v[0] && t == t0) || (v[1] && t == t1);
   endfunction

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic model_step(bit dv, logic [OW-1:0] op, logic [TW-1:0] s1, bit r1,
                             logic [TW-1:0] s2, bit r2, logic [TW-1:0] dst,
                             logic [1:0] wv, logic [TW-1:0] t0, logic [TW-1:0] t1, bit fl);
      bit rdy_pre;
      int f0, f1, tb, slot;
      rdy_pre = (mfree(0) > 0) || (mfree(1) > 0);
      f0 = mfree(0);
      f1 = mfree(1);
      if (fl) begin
         for (int b = 0; b < 2; b++) begin
            ev[b] = 1'b0;
            for (int i = 0; i < D; i++) mv[b][i] = 1'b0;
         end
         return;
      end
      slot = -1;
      tb = (f1 > f0) ? 1 : 0;
      if (dv && rdy_pre)
         for (int i = D - 1; i >= 0; i--) if (!mv[tb][i]) slot = i;
      for (int b = 0; b < 2; b++) begin
         int best = -1;
         for (int i = 0; i < D; i++)
            if (mv[b][i] && mr1[b][i] && mr2[b][i] && (best < 0 || mseq[b][i] < mseq[b][best])) best = i;
         ev[b] = (best >= 0);
         if (best >= 0) begin
            epl[b] = {mop[b][best], mdst[b][best], ms2[b][best], ms1[b][best]};
            mv[b][best] = 1'b0;
         end
         for (int i = 0; i < D; i++) begin
            if (mhit(ms1[b][i], wv, t0, t1)) mr1[b][i] = 1'b1;
            if (mhit(ms2[b][i], wv, t0, t1)) mr2[b][i] = 1'b1;
         end
      end
      if (slot >= 0) begin
         mv[tb][slot]   = 1'b1;
         mr1[tb][slot]  = r1 || mhit(s1, wv, t0, t1);
         mr2[tb][slot]  = r2 || mhit(s2, wv, t0, t1);
         ms1[tb][slot]  = s1;
         ms2[tb][slot]  = s2;
         mdst[tb][slot] = dst;
         mop[tb][slot]  = op;
         mseq[tb][slot] = seq_ctr;
         seq_ctr++;
      end
   endtask

   // called just after a falling edge
   task automatic cyc(bit dv, logic [OW-1:0] op, logic [TW-1:0] s1, bit r1,
                      logic [TW-1:0] s2, bit r2, logic [TW-1:0] dst,
                      logic [1:0] wv, logic [TW-1:0] t0, logic [TW-1:0] t1, bit fl, string req);
      bit exp_rdy;
      disp_valid = dv; disp_op = op; disp_src1 = s1; disp_src1_rdy = r1;
      disp_src2 = s2; disp_src2_rdy = r2; disp_dst = dst;
      wk_valid = wv; wk_tag = {t1, t0}; flush = fl;
      #1;
      exp_rdy = (mfree(0) > 0) || (mfree(1) > 0);
      chk(disp_ready == exp_rdy, "R3", "disp_ready", longint'(disp_ready), longint'(exp_rdy));
      model_step(dv, op, s1, r1, s2, r2, dst, wv, t0, t1, fl);
      @(posedge clk);
      @(negedge clk);
      for (int b = 0; b < 2; b++) begin
         chk(iss_valid[b] == ev[b], req, $sformatf("iss_valid[%0d]", b), longint'(iss_valid[b]), longint'(ev[b]));
         if (ev[b] && iss_valid[b]) begin
            logic [OW+3*TW-1:0] act;
            act = {iss_op[b*OW +: OW], iss_dst[b*TW +: TW], iss_src2[b*TW +: TW], iss_src1[b*TW +: TW]};
            chk(act == epl[b], req, $sformatf("payload bank%0d", b), longint'(act), longint'(epl[b]));
         end
      end
      issued += int'(iss_valid[0]) + int'(iss_valid[1]);
      if (iss_valid == 2'b11) both_cycles++;
   endtask

   task automatic idle(int n, string req);
      for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, 0, 0, 0, 2'b00, 0, 0, 0, req);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1D5EED));
      repeat (3) @(negedge clk);
      chk(iss_valid == 2'b00, "R1", "iss_valid in reset", longint'(iss_valid), 0);
      chk(disp_ready == 1'b1, "R1", "disp_ready in reset", longint'(disp_ready), 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk(iss_valid == 2'b00, "R1", "iss_valid after reset", longint'(iss_valid), 0);

      // R7: ready-at-dispatch instruction appears two edges later
      cyc(1, 8'hA5, 6'd1, 1, 6'd2, 1, 6'd3, 2'b00, 0, 0, 0, "R7");
      chk(iss_valid == 2'b00, "R7", "no issue one edge after dispatch", longint'(iss_valid), 0);
      cyc(0, 0, 0, 0, 0, 0, 0, 2'b00, 0, 0, 0, "R7");
      chk(iss_valid[0] == 1'b1 && iss_op[OW-1:0] == 8'hA5, "R7", "issue two edges after dispatch",
          longint'(iss_op[OW-1:0]), 64'hA5);
      idle(2, "R7");

      // R2 R3: fill both banks with blocked entries, opcode = order
      for (int k = 0; k < 2 * D; k++)
         cyc(1, OW'(k), 6'd40, 0, 6'd5, 1, TW'(k), 2'b00, 0, 0, 0, "R2");
      #1;
      chk(disp_ready == 1'b0, "R3", "disp_ready when full", longint'(disp_ready), 0);
      cyc(1, 8'hEE, 6'd1, 1, 6'd1, 1, 6'd9, 2'b00, 0, 0, 0, "R3");
      // R5: wake on lane 1; no issue one edge later
      issued = 0;
      both_cycles = 0;
      cyc(0, 0, 0, 0, 0, 0, 0, 2'b10, 6'd0, 6'd40, 0, "R5");
      chk(iss_valid == 2'b00, "R5", "no issue one edge after wakeup", longint'(iss_valid), 0);
      cyc(0, 0, 0, 0, 0, 0, 0, 2'b00, 0, 0, 0, "R6");
      chk(iss_op[OW-1:0] == 8'd0 && iss_op[2*OW-1:OW] == 8'd1, "R6", "oldest first per bank",
          longint'(iss_op), 64'h0100);
      idle(9, "R6");
      chk(issued == 2 * D, "R3", "entries drained (full dispatch dropped)", issued, 2 * D);
      chk(both_cycles == D, "R4", "cycles with both banks issuing", both_cycles, D);

      // R5: wakeup in the same cycle as dispatch
      cyc(1, 8'h41, 6'd41, 0, 6'd7, 1, 6'd8, 2'b01, 6'd41, 6'd0, 0, "R5");
      idle(3, "R5");

      // R8: flush drops queued entries and the dispatch in the flush cycle
      for (int k = 0; k < 4; k++)
         cyc(1, OW'(8'h80 + k), 6'd42, 0, 6'd42, 0, 6'd1, 2'b00, 0, 0, 0, "R8");
      cyc(1, 8'h99, 6'd1, 1, 6'd1, 1, 6'd1, 2'b00, 0, 0, 1, "R8");
      chk(iss_valid == 2'b00, "R8", "issue after flush", longint'(iss_valid), 0);
      cyc(0, 0, 0, 0, 0, 0, 0, 2'b11, 6'd42, 6'd42, 0, "R8");
      idle(4, "R8");
      chk(issued == 2 * D + 1, "R8", "total issued after flush", issued, 2 * D + 1);

      // random mix
      for (int n = 0; n < 3000; n++) begin
         bit dv, r1, r2, fl;
         logic [1:0] wv;
         dv = ($urandom % 10) < 7;
         r1 = $urandom % 2;
         r2 = $urandom % 2;
         wv = {($urandom % 10) < 4, ($urandom % 10) < 4};
         fl = ($urandom % 200) == 0;
         cyc(dv, OW'($urandom), TW'($urandom % 16), r1, TW'($urandom % 16), r2, TW'($urandom % 16),
             wv, TW'($urandom % 16), TW'($urandom % 16), fl, "R2 R4 R5 R6 R7");
      end
      idle(2, "R7");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule